// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break and Flow Gate

This block turns bytes into asynchronous serial characters on a single output line. The character shape is set by a run-time setup word: how many clocks make up one bit, how many data bits to send (five to eight), whether a parity bit follows and what kind, and whether one or two stop bits close the character. A byte is offered on `stb_i` with `data_i`. It is taken only when `busy_o` is low. When the block takes a byte, it also captures the framing and bit rate from the setup word, so a later change of setup only affects the next character.

Two controls sit on top of the framing. A break request on `brk_i` drives the line low for as long as it is held. A break aborts any character in progress and drops any byte waiting for flow control. After the break is released, the line stays high for one full bit time before the block returns to idle. An active-low clear-to-send input, `cts_n_i`, holds back the start of a new character while it is high. It is only looked at between characters, and setup bit 30 turns this gating off.

The controller has eight states:
- `ST_IDLE`: the line is high and a byte may be taken.
- `ST_HOLD`: a byte has been taken and is waiting for clear-to-send.
- `ST_START`, `ST_DATA`, `ST_PARITY`, `ST_STOP`: one bit time for each bit of the character.
- `ST_BREAK`: the line is low.
- `ST_RECOVER`: one high bit time after a break.

The transitions are:
- IDLE→START: a byte is taken and sending is allowed.
- IDLE→HOLD: a byte is taken but flow control blocks it.
- HOLD→START: flow control releases the byte.
- START→DATA: the start bit time ends.
- DATA→DATA: a data bit time ends and more data bits remain.
- DATA→PARITY or DATA→STOP: the last data bit time ends; PARITY is taken when parity is enabled.
- PARITY→STOP: the parity bit time ends.
- STOP→STOP: the first of two stop bits ends.
- STOP→IDLE: the last stop bit ends.
- any→BREAK: `brk_i` is high.
- BREAK→RECOVER: `brk_i` is low.
- RECOVER→IDLE: the recovery bit time ends.

Top module: `uart_tx_core`

## Requirements
- R1: After a synchronous reset, `tx_o` is high and `busy_o` is low.
- R2: A byte is taken on a rising clock edge where `stb_i` is high and `busy_o` is low. With flow control not blocking, the start bit begins right after that edge. A strobe while `busy_o` is high is ignored, and no extra character follows.
- R3: A character is sent in this order:
  - one start bit (low);
  - N data bits, least significant bit first, where N = 8 − setup[29:28] (code 0→8, 1→7, 2→6, 3→5);
  - then the parity and stop bits.
  Every bit lasts D clocks, where D = setup[23:0] and a value of 0 counts as 1.
- R4: Setup bit 26 adds one parity bit after the data bits.
  - When bit 25 is 1, the parity bit equals bit 24.
  - Otherwise, bit 24 = 0 gives even parity and bit 24 = 1 gives odd parity over the N data bits sent.
- R5: Setup bit 27 = 1 sends two stop bits, and 0 sends one stop bit. Stop bits are high.
- R6: `busy_o` is high from the edge that takes a byte until the last stop bit ends, and it falls exactly at that point. While `busy_o` is low, the line is high.
- R7: When setup bit 30 is 0 and `cts_n_i` is high, a byte that has been taken waits with the line high and `busy_o` high. Its start bit begins right after the first edge where `cts_n_i` is sampled low.
- R8: When setup bit 30 is 1, `cts_n_i` has no effect: a character starts right after the byte is taken, even with `cts_n_i` high.
- R9: A change on `cts_n_i` after the start bit has begun does not change the character; it completes in full.
- R10: From the first edge where `brk_i` is sampled high, `tx_o` is low and `busy_o` is high, whether or not a character is in progress.
  - The interrupted character is abandoned.
  - A strobe that coincides with the break, or arrives during it, sends nothing.
- R11: After the first edge where `brk_i` is sampled low in `ST_BREAK`, the line is high and `busy_o` stays high for exactly D clocks. After that the block is idle.
- R12: The framing and bit time of a character come from the setup word at the edge that takes its byte. Later setup changes do not affect that character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| setup_i | input | 31 | Setup word: [23:0] clocks per bit, [24] parity select, [25] fixed parity, [26] parity enable, [27] two stop bits, [29:28] length code, [30] flow control off |
| stb_i | input | 1 | Byte offer strobe |
| data_i | input | 8 | Byte to send |
| brk_i | input | 1 | Break request; holds the line low |
| cts_n_i | input | 1 | Clear to send, active low |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a byte is held, being sent, or a break or its recovery is active |

## Verification
The bench builds the block with its default parameters: a 24-bit divisor and an 8-bit data path. Every framing choice is a run-time setup field, so the bench reaches all four length codes, every parity mode and both stop-bit counts without rebuilding. It uses bit times of 1 to 5 clocks, which keeps each character within a few dozen cycles. Those short bit times make it cheap to hit the corners:
- a divisor of one;
- a break that cuts a character in the middle;
- a break that meets a strobe in the same cycle;
- a clear-to-send that toggles in the middle of a character;
- a setup change right after a byte is taken.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // Setup word field positions (shared layout with the companion receiver)
    localparam int PSEL_BIT     = 24;
    localparam int PFIX_BIT     = 25;
    localparam int PEN_BIT      = 26;
    localparam int STOP2_BIT    = 27;
    localparam int LEN_LO       = 28;
    localparam int LEN_HI       = 29;
    localparam int FLOW_OFF_BIT = 30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK,
        ST_RECOVER
    } tx_state_e;

    // Parity bit from the odd-ones flag of the sent data bits
    function automatic logic parity_bit(input logic ones_odd,
                                        input logic fixed,
                                        input logic sel);
        return fixed ? sel : (ones_odd ^ sel);
    endfunction

    // A state in which the bit timer paces the line
    function automatic logic is_timed(input tx_state_e s);
        return (s == ST_START) || (s == ST_DATA) || (s == ST_PARITY) ||
               (s == ST_STOP)  || (s == ST_RECOVER);
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;

    // A divisor of zero behaves as one clock per bit
    always_comb begin
        reload = '0;
        if (div_i != '0) begin
            reload = div_i - DIV_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DIV_W'(1);
        end
    end

    assign tick_o = (cnt_q == '0);

    // R3: after a reload with a divisor above one, the bit cannot end on the next cycle
    a_r3_reload_gap: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && (div_i > DIV_W'(1))) |=> !tick_o);

    // R3: the count only falls by one per clock unless reloaded
    a_r3_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - DIV_W'(1)));

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic              par_en_i,
    input  logic              par_fix_i,
    input  logic              par_sel_i,
    input  logic              two_stop_i,
    input  logic              shift_i,
    input  logic              stop_adv_i,
    output logic              bit_o,
    output logic              par_bit_o,
    output logic              par_en_o,
    output logic              last_data_o,
    output logic              last_stop_o
);

    import uart_tx_pkg::*;

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  left_q;
    logic              par_q;
    logic              pen_q;
    logic              stop_more_q;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] kept;

    // Keep only the data bits that the length code selects
    always_comb begin
        for (int k = 0; k < DATA_W; k++) begin
            mask[k] = (k < int'(nbits_i));
        end
        kept = data_i & mask;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q        <= '0;
            left_q      <= '0;
            par_q       <= 1'b0;
            pen_q       <= 1'b0;
            stop_more_q <= 1'b0;
        end else if (capture_i) begin
            sh_q        <= kept;
            left_q      <= nbits_i;
            par_q       <= parity_bit(^kept, par_fix_i, par_sel_i);
            pen_q       <= par_en_i;
            stop_more_q <= two_stop_i;
        end else begin
            if (shift_i) begin
                sh_q   <= sh_q >> 1;
                left_q <= left_q - CNT_W'(1);
            end
            if (stop_adv_i) begin
                stop_more_q <= 1'b0;
            end
        end
    end

    assign bit_o       = sh_q[0];
    assign par_bit_o   = par_q;
    assign par_en_o    = pen_q;
    assign last_data_o = (left_q <= CNT_W'(1));
    assign last_stop_o = !stop_more_q;

    // R3: the remaining-bit count never exceeds the data width
    a_r3_count_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        left_q <= CNT_W'(DATA_W));

    // R3: a capture loads at least five data bits
    a_r3_min_length: assert property (@(posedge clk_i) disable iff (rst_i)
        capture_i |=> (left_q >= CNT_W'(DATA_W - 3)));

    // R5: the second stop bit is consumed by the first stop advance
    a_r5_stop_once: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_adv_i && !capture_i) |=> last_stop_o);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DIV_W   = 24,
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 31
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [SETUP_W-1:0] setup_i,
    input  logic               stb_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic               brk_i,
    input  logic               cts_n_i,
    output logic               tx_o,
    output logic               busy_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int LEN_W = LEN_HI - LEN_LO + 1;

    tx_state_e state_q;
    tx_state_e state_d;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic [LEN_W-1:0] len_code;
    logic [CNT_W-1:0] nbits;
    logic             flow_block;
    logic             tick;
    logic             load;
    logic             capture;
    logic             shift;
    logic             stop_adv;
    logic             data_bit;
    logic             par_bit;
    logic             par_en_q;
    logic             last_data;
    logic             last_stop;

    // Setup decode
    assign len_code   = setup_i[LEN_HI:LEN_LO];
    assign nbits      = CNT_W'(DATA_W - int'(len_code));
    assign flow_block = !setup_i[FLOW_OFF_BIT] && cts_n_i;

    // Bit time follows the live setup only while no character is held
    assign div_eff = ((state_q == ST_IDLE) || (state_q == ST_BREAK))
                   ? setup_i[DIV_W-1:0] : div_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_eff;
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (brk_i) begin
            state_d = ST_BREAK;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (stb_i) begin
                        state_d = flow_block ? ST_HOLD : ST_START;
                    end
                end
                ST_HOLD: begin
                    if (!flow_block) begin
                        state_d = ST_START;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        state_d = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (tick && last_data) begin
                        state_d = par_en_q ? ST_PARITY : ST_STOP;
                    end
                end
                ST_PARITY: begin
                    if (tick) begin
                        state_d = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (tick && last_stop) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_BREAK: begin
                    state_d = ST_RECOVER;
                end
                ST_RECOVER: begin
                    if (tick) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath strobes
    assign capture  = (state_q == ST_IDLE) && stb_i && !brk_i;
    assign shift    = (state_q == ST_DATA) && tick && !brk_i;
    assign stop_adv = (state_q == ST_STOP) && tick && !brk_i;
    assign load     = (state_d != state_q) ||
                      (tick && ((state_q == ST_DATA) || (state_q == ST_STOP)));

    uart_tx_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .div_i  (div_eff),
        .tick_o (tick)
    );

    uart_tx_shift #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .capture_i   (capture),
        .data_i      (data_i),
        .nbits_i     (nbits),
        .par_en_i    (setup_i[PEN_BIT]),
        .par_fix_i   (setup_i[PFIX_BIT]),
        .par_sel_i   (setup_i[PSEL_BIT]),
        .two_stop_i  (setup_i[STOP2_BIT]),
        .shift_i     (shift),
        .stop_adv_i  (stop_adv),
        .bit_o       (data_bit),
        .par_bit_o   (par_bit),
        .par_en_o    (par_en_q),
        .last_data_o (last_data),
        .last_stop_o (last_stop)
    );

    // Outputs
    always_comb begin
        tx_o = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_HOLD, ST_STOP, ST_RECOVER: tx_o = 1'b1;
            ST_START, ST_BREAK:                    tx_o = 1'b0;
            ST_DATA:                               tx_o = data_bit;
            ST_PARITY:                             tx_o = par_bit;
            default:                               tx_o = 1'b1;
        endcase
        busy_o = (state_q != ST_IDLE) || brk_i;
    end

    // R2: a byte taken with sending allowed starts with a low start bit
    a_r2_accept_starts: assert property (@(posedge clk_i) disable iff (rst_i)
        (stb_i && !busy_o && !flow_block) |=> (!tx_o && busy_o));

    // R6: an idle block leaves the line high
    a_r6_idle_line_high: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> tx_o);

    // R7: a held byte keeps waiting while clear-to-send is high
    a_r7_hold_waits: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q == ST_HOLD) && flow_block && !brk_i) |=> ((state_q == ST_HOLD) && tx_o && busy_o));

    // R10: a sampled break drives the line low on the following cycle
    a_r10_break_low: assert property (@(posedge clk_i) disable iff (rst_i)
        brk_i |=> (!tx_o && busy_o));

    // R11: release of a break yields a high, busy recovery bit
    a_r11_release_high: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q == ST_BREAK) && !brk_i) |=> (tx_o && busy_o));

    // R12: the captured bit time stays fixed while a character is under way
    a_r12_div_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        ((state_q != ST_IDLE) && (state_q != ST_BREAK) && !brk_i) |=> $stable(div_q));

endmodule

// File: tb/uart_tx_core_test.sv
module uart_tx_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] setup = 31'd4;
    logic        stb = 1'b0;
    logic [7:0]  data = 8'h00;
    logic        brk = 1'b0;
    logic        cts_n = 1'b0;
    logic        tx;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    uart_tx_core uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .setup_i (setup),
        .stb_i   (stb),
        .data_i  (data),
        .brk_i   (brk),
        .cts_n_i (cts_n),
        .tx_o    (tx),
        .busy_o  (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Setup word: [30] flow off, [29:28] length code, [27] two stops,
    // [26] parity on, [25] fixed parity, [24] parity select, [23:0] clocks per bit
    function automatic logic [30:0] mk(input bit foff, input int code, input bit two,
                                       input bit pen, input bit pfix, input bit psel,
                                       input int d);
        return {foff, 2'(code), two, pen, pfix, psel, 24'(d)};
    endfunction

    // Vector table: {setup, data}
    localparam logic [38:0] VEC [6] = '{
        {31'h0000_0004, 8'hA5},   // 8N1, D=4
        {31'h1400_0003, 8'hD3},   // 7 bits, even parity, D=3
        {31'h2D00_0005, 8'h2C},   // 6 bits, odd parity, 2 stops, D=5
        {31'h3600_0002, 8'h1F},   // 5 bits, fixed parity 0, D=2
        {31'h0F00_0001, 8'h80},   // 8 bits, fixed parity 1, 2 stops, D=1
        {31'h0000_0000, 8'h3C}    // 8N1, divisor 0 acts as 1
    };

    // Send one character and compare it against the frame from the requirements
    task automatic run_frame(input logic [30:0] s, input logic [7:0] d,
                             input logic [30:0] s_after, input bit cts_mid,
                             input bit poke);
        bit     exp_bits [16];
        string  tags [16];
        int     nb = 0;
        int     dd;
        int     n;
        bit     ones;
        bit     busy_ok = 1'b1;
        dd   = (s[23:0] == 0) ? 1 : int'(s[23:0]);
        n    = 8 - int'(s[29:28]);
        ones = 1'b0;
        exp_bits[nb] = 1'b0; tags[nb] = "R3 start"; nb++;
        for (int k = 0; k < n; k++) begin
            exp_bits[nb] = d[k]; tags[nb] = "R3 data"; nb++;
            ones ^= d[k];
        end
        if (s[26]) begin
            exp_bits[nb] = s[25] ? s[24] : (ones ^ s[24]); tags[nb] = "R4 parity"; nb++;
        end
        exp_bits[nb] = 1'b1; tags[nb] = "R5 stop"; nb++;
        if (s[27]) begin
            exp_bits[nb] = 1'b1; tags[nb] = "R5 stop2"; nb++;
        end
        @(negedge clk);
        setup = s; data = d; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0; setup = s_after;
        for (int i = 0; i < nb * dd; i++) begin
            if ((i % dd) == (dd / 2)) begin
                chk(tx == exp_bits[i / dd], tags[i / dd], int'(tx), int'(exp_bits[i / dd]));
            end
            if (!busy) busy_ok = 1'b0;
            if (cts_mid && i == dd) cts_n = 1'b1;
            if (poke && i == dd) begin stb = 1'b1; data = 8'h00; end
            if (poke && i == dd + 1) stb = 1'b0;
            @(negedge clk);
        end
        chk(busy_ok, "R6 busy through frame", int'(busy_ok), 1);
        chk(!busy && tx, "R6 busy falls at end", int'(busy), 0);
        if (cts_mid) cts_n = 1'b0;
        if (poke) begin
            bit quiet = 1'b1;
            for (int i = 0; i < 3 * dd + 4; i++) begin
                if (!tx || busy) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R2 strobe while busy ignored", int'(quiet), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(tx == 1'b1, "R1 line high", int'(tx), 1);
        chk(busy == 1'b0, "R1 not busy", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);

        // Table of framings (R3, R4, R5, R6)
        for (int v = 0; v < 6; v++) begin
            run_frame(VEC[v][38:8], VEC[v][7:0], VEC[v][38:8], 1'b0, 1'b0);
        end

        // R12: setup change right after acceptance
        run_frame(mk(0, 0, 0, 1, 0, 1, 3), 8'h96, mk(0, 3, 1, 0, 0, 0, 7), 1'b0, 1'b0);

        // R2: strobe while busy
        run_frame(mk(0, 0, 0, 0, 0, 0, 3), 8'h5A, mk(0, 0, 0, 0, 0, 0, 3), 1'b0, 1'b1);

        // R9: clear-to-send rises mid character
        run_frame(mk(0, 0, 0, 1, 0, 0, 2), 8'hC3, mk(0, 0, 0, 1, 0, 0, 2), 1'b1, 1'b0);

        // R8: flow control disabled, clear-to-send held high
        cts_n = 1'b1;
        run_frame(mk(1, 0, 0, 0, 0, 0, 2), 8'h71, mk(1, 0, 0, 0, 0, 0, 2), 1'b0, 1'b0);

        // R7: byte held while clear-to-send is high
        begin
            bit held = 1'b1;
            int waitc = 0;
            @(negedge clk);
            setup = mk(0, 0, 0, 0, 0, 0, 3); data = 8'hFF; stb = 1'b1;
            @(negedge clk);
            stb = 1'b0;
            for (int i = 0; i < 10; i++) begin
                if (!tx || !busy) held = 1'b0;
                @(negedge clk);
            end
            chk(held, "R7 line high and busy while held", int'(held), 1);
            cts_n = 1'b0;
            @(negedge clk);
            chk(tx == 1'b0 && busy, "R7 start after release", int'(tx), 0);
            while (busy && waitc < 200) begin
                waitc++;
                @(negedge clk);
            end
            chk(!busy, "R7 held character completes", int'(busy), 0);
        end

        // R10 / R11: break in the middle of a character, with a strobe inside
        begin
            bit low_ok = 1'b1;
            bit rec_ok = 1'b1;
            bit quiet = 1'b1;
            @(negedge clk);
            setup = mk(0, 0, 0, 0, 0, 0, 4); data = 8'hFF; stb = 1'b1;
            @(negedge clk);
            stb = 1'b0;
            repeat (6) @(negedge clk);
            brk = 1'b1;
            @(negedge clk);
            chk(tx == 1'b0 && busy, "R10 break drives line low", int'(tx), 0);
            for (int i = 0; i < 15; i++) begin
                if (i == 3) begin stb = 1'b1; data = 8'hAA; end
                if (i == 4) stb = 1'b0;
                if (tx || !busy) low_ok = 1'b0;
                @(negedge clk);
            end
            chk(low_ok, "R10 line low and busy throughout break", int'(low_ok), 1);
            brk = 1'b0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (!tx || !busy) rec_ok = 1'b0;
            end
            chk(rec_ok, "R11 high busy recovery bit", int'(rec_ok), 1);
            @(negedge clk);
            chk(!busy && tx, "R11 idle after recovery", int'(busy), 0);
            for (int i = 0; i < 20; i++) begin
                if (!tx || busy) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R10 aborted and strobed bytes not sent", int'(quiet), 1);
        end

        // R10: break and strobe in the same cycle from idle
        begin
            bit quiet = 1'b1;
            setup = mk(0, 0, 0, 0, 0, 0, 2); data = 8'h00; stb = 1'b1; brk = 1'b1;
            @(negedge clk);
            stb = 1'b0;
            chk(tx == 1'b0 && busy, "R10 break wins over strobe", int'(tx), 0);
            brk = 1'b0;
            repeat (3) @(negedge clk);
            for (int i = 0; i < 20; i++) begin
                if (!tx || busy) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R10 coincident strobe dropped", int'(quiet), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule